// File: doc/BRIEF.md
# Load-ALU Fusion Slot Classifier

This block sits between instruction decode and rename/issue. Each incoming instruction carries an opcode class, the kind of destination it writes (plain register, memory, or a register that is both read and written), how it addresses memory (no memory at all, base only, base plus index, or relative to the instruction pointer) and whether it carries an immediate. For each instruction the block decides whether the load part and the ALU part can share one front-end slot, or whether they must be split into two slots before issue.

Each decision becomes one or two slot records on a valid/ready output toward rename/issue. When a slot is transferred, the block also flags which execution-unit uops it accounts for: a load uop, an ALU uop, or both. A fused slot always stands for two execution uops, because fusion only saves front-end bandwidth. Two counters track the fused view and the unfused view. The first counts slots handed to issue. The second counts execution uops. On a stream of fused memory instructions the second counter pulls ahead of the first by one per instruction.

Top module: `mfuse_classifier`

## Requirements
- R1: An instruction with addressing mode 0 (no memory operand) produces exactly one slot of kind 0 (plain), which flags only the ALU uop.
- R2: Addressing mode 1 (base only) and mode 3 (instruction-pointer relative) without an immediate produce one slot of kind 1 (fused), which flags both the load uop and the ALU uop.
- R3: Mode 3 together with an immediate (`in_imm`=1) never fuses. It produces a slot of kind 2 (load only) followed by a slot of kind 3 (ALU only), whatever the destination.
- R4: Mode 2 (base plus index) with destination kind 0 (register) or 1 (memory) is split into a kind-2 slot followed by a kind-3 slot.
- R5: Mode 2 with destination kind 2 (read-and-written register) and no immediate stays fused as one kind-1 slot.
- R6: While the load half of a split instruction is being presented, `in_ready` is low. The very next slot transferred is that instruction's ALU half, with the same tag and opcode class.
- R7: While `slot_valid` is high and `slot_ready` is low, the slot record (kind, tag, opcode class) holds steady.
- R8: `cnt_issued` rises by one for each slot transferred. `cnt_executed` rises by the number of uops flagged on that transfer: 2 for kind 1, and 1 for any other kind.
- R9: Both counters are `CNT_W` bits wide and wrap modulo 2^`CNT_W`. A high `cnt_clr` zeroes both counters at the next edge, and it takes priority over a transfer in the same cycle.
- R10: After reset, `slot_valid` is low and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_op | input | OP_W | Opcode class, passed through |
| in_dst | input | 2 | Destination kind: 0 reg, 1 mem, 2 read-and-written reg |
| in_mode | input | 2 | Addressing: 0 none, 1 base, 2 base+index, 3 IP-relative |
| in_imm | input | 1 | Immediate operand present |
| in_tag | input | TAG_W | Instruction tag, passed through |
| slot_valid | output | 1 | Slot record presented |
| slot_ready | input | 1 | Rename/issue takes the slot |
| slot_kind | output | 2 | 0 plain, 1 fused, 2 load half, 3 ALU half |
| slot_op | output | OP_W | Opcode class of the slot |
| slot_tag | output | TAG_W | Tag of the slot |
| exe_load_v | output | 1 | Load uop sent on this transfer |
| exe_alu_v | output | 1 | ALU uop sent on this transfer |
| cnt_issued | output | CNT_W | Fused-domain slots issued |
| cnt_executed | output | CNT_W | Unfused-domain uops sent |

## Verification
The properties assume that the downstream side follows valid/ready rules, and that `rst_n` is low from time zero until the first edges have passed. They also assume that destination code 3 is never sent and that `cnt_clr` is driven with a known value at every edge. The stimulus drives inputs one time unit after each rising edge, never uses the reserved destination code, and holds `cnt_clr` at a defined level throughout. It applies backpressure in bursts, so that a split's load half and hold periods both occur while the upstream keeps offering work.

// File: rtl/mfuse_pkg.sv
// Package: shared encodings for the fusion slot classifier.
// Assumes: all users pack these enums into 2-bit port fields.
package mfuse_pkg;

    typedef enum logic [1:0] {
        MODE_NOMEM = 2'd0,
        MODE_BASE  = 2'd1,
        MODE_INDEX = 2'd2,
        MODE_IPREL = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        DST_REG = 2'd0,
        DST_MEM = 2'd1,
        DST_RMW = 2'd2,
        DST_RSV = 2'd3
    } dst_kind_e;

    typedef enum logic [1:0] {
        SK_PLAIN = 2'd0,
        SK_FUSED = 2'd1,
        SK_LOAD  = 2'd2,
        SK_ALU   = 2'd3
    } slot_kind_e;

endpackage

// File: rtl/mfuse_decide.sv
// Module: mfuse_decide
// Purely combinational fusion decision for one instruction.
// Assumes: destination code 3 is not used; it is treated as a plain register.
module mfuse_decide
    import mfuse_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [1:0] dst,
    input  logic       imm,
    output logic [1:0] first_kind,
    output logic       split
);

    addr_mode_e mode_e;
    dst_kind_e  dst_e;
    logic       iprel_imm;
    logic       index_unlam;

    assign mode_e = addr_mode_e'(mode);
    assign dst_e  = dst_kind_e'(dst);

    // Purpose: find the two conditions that break a load-ALU pair apart.
    always_comb begin
        iprel_imm   = (mode_e == MODE_IPREL) && imm;
        index_unlam = (mode_e == MODE_INDEX) && (dst_e != DST_RMW);
    end

    // Purpose: choose the kind of the first slot and whether a second follows.
    always_comb begin
        split      = 1'b0;
        first_kind = SK_FUSED;
        if (mode_e == MODE_NOMEM) begin
            first_kind = SK_PLAIN;
        end else if (iprel_imm || index_unlam) begin
            split      = 1'b1;
            first_kind = SK_LOAD;
        end
    end

endmodule

// File: rtl/mfuse_slot_seq.sv
// Module: mfuse_slot_seq
// One-entry output register that presents one or two slots per instruction.
// Assumes: downstream obeys valid/ready; a split always yields load then ALU.
module mfuse_slot_seq
    import mfuse_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int OP_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OP_W-1:0]  in_op,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [1:0]       dec_kind,
    input  logic             dec_split,
    output logic             slot_valid,
    input  logic             slot_ready,
    output logic [1:0]       slot_kind,
    output logic [OP_W-1:0]  slot_op,
    output logic [TAG_W-1:0] slot_tag,
    output logic             slot_fire
);

    logic             v_q;
    logic             pend_q;
    slot_kind_e       kind_q;
    logic [OP_W-1:0]  op_q;
    logic [TAG_W-1:0] tag_q;
    logic             in_fire;

    // Purpose: handshake terms on both sides.
    always_comb begin
        slot_fire = v_q && slot_ready;
        in_ready  = !pend_q && (!v_q || slot_ready);
        in_fire   = in_valid && in_ready;
    end

    // Purpose: advance the held record, emitting the ALU half after a load half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            pend_q <= 1'b0;
            kind_q <= SK_PLAIN;
            op_q   <= '0;
            tag_q  <= '0;
        end else if (slot_fire && pend_q) begin
            kind_q <= SK_ALU;
            pend_q <= 1'b0;
        end else if (in_fire) begin
            v_q    <= 1'b1;
            kind_q <= slot_kind_e'(dec_kind);
            pend_q <= dec_split;
            op_q   <= in_op;
            tag_q  <= in_tag;
        end else if (slot_fire) begin
            v_q <= 1'b0;
        end
    end

    assign slot_valid = v_q;
    assign slot_kind  = kind_q;
    assign slot_op    = op_q;
    assign slot_tag   = tag_q;

    // R6: no new instruction while a second half is owed.
    p_ready_low_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && slot_kind_e'(slot_kind) == SK_LOAD) |-> !in_ready);

    // R6: a transferred load half is followed by its ALU half.
    p_alu_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fire && slot_kind_e'(slot_kind) == SK_LOAD)
        |=> (slot_valid && slot_kind_e'(slot_kind) == SK_ALU && $stable(slot_tag)));

    // R7: a stalled record does not move.
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !slot_ready)
        |=> (slot_valid && $stable(slot_kind) && $stable(slot_tag) && $stable(slot_op)));

endmodule

// File: rtl/mfuse_counters.sv
// Module: mfuse_counters
// Fused-domain slot counter and unfused-domain uop counter.
// Assumes: uop_n is 1 or 2 whenever slot_inc is high.
module mfuse_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             slot_inc,
    input  logic [1:0]       uop_n,
    output logic [CNT_W-1:0] issued,
    output logic [CNT_W-1:0] executed
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Purpose: accumulate with wrap; clear wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            issued   <= '0;
            executed <= '0;
        end else if (slot_inc) begin
            issued   <= issued + ONE;
            executed <= executed + CNT_W'(uop_n);
        end
    end

    // R9: clear zeroes both counters at the next edge.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (issued == '0 && executed == '0));

    // R8: one slot per transfer on the issued counter.
    p_issue_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && slot_inc) |=> (issued == CNT_W'($past(issued) + ONE)));

    // R8: executed moves by one or two per transfer.
    p_exec_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && slot_inc) |=> (executed != $past(executed)));

endmodule

// File: rtl/mfuse_classifier.sv
// Module: mfuse_classifier (top)
// Decides load/ALU fusion per memory instruction, emits slots and uop flags,
// and counts fused-domain slots and unfused-domain uops.
// Assumes: one instruction per cycle at most; destination code 3 unused.
module mfuse_classifier
    import mfuse_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int OP_W  = 3,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OP_W-1:0]  in_op,
    input  logic [1:0]       in_dst,
    input  logic [1:0]       in_mode,
    input  logic             in_imm,
    input  logic [TAG_W-1:0] in_tag,
    output logic             slot_valid,
    input  logic             slot_ready,
    output logic [1:0]       slot_kind,
    output logic [OP_W-1:0]  slot_op,
    output logic [TAG_W-1:0] slot_tag,
    output logic             exe_load_v,
    output logic             exe_alu_v,
    output logic [CNT_W-1:0] cnt_issued,
    output logic [CNT_W-1:0] cnt_executed
);

    logic [1:0] dec_kind;
    logic       dec_split;
    logic       slot_fire;
    logic [1:0] uop_n;
    slot_kind_e kind_e;

    mfuse_decide u_decide (
        .mode       (in_mode),
        .dst        (in_dst),
        .imm        (in_imm),
        .first_kind (dec_kind),
        .split      (dec_split)
    );

    mfuse_slot_seq #(.TAG_W(TAG_W), .OP_W(OP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_op      (in_op),
        .in_tag     (in_tag),
        .dec_kind   (dec_kind),
        .dec_split  (dec_split),
        .slot_valid (slot_valid),
        .slot_ready (slot_ready),
        .slot_kind  (slot_kind),
        .slot_op    (slot_op),
        .slot_tag   (slot_tag),
        .slot_fire  (slot_fire)
    );

    assign kind_e = slot_kind_e'(slot_kind);

    // Purpose: map the transferred slot kind onto execution-unit uops.
    always_comb begin
        exe_load_v = slot_fire && (kind_e == SK_FUSED || kind_e == SK_LOAD);
        exe_alu_v  = slot_fire && (kind_e != SK_LOAD);
        uop_n      = {1'b0, exe_load_v} + {1'b0, exe_alu_v};
    end

    mfuse_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .slot_inc (slot_fire),
        .uop_n    (uop_n),
        .issued   (cnt_issued),
        .executed (cnt_executed)
    );

    // R1: a plain slot never carries a load uop.
    p_plain_no_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && kind_e == SK_PLAIN) |-> !exe_load_v);

    // R2: a fused slot always sends both uops.
    p_fused_two_uops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_ready && kind_e == SK_FUSED) |-> (exe_load_v && exe_alu_v));

endmodule

// File: tb/tb_mfuse_classifier.sv
module tb_mfuse_classifier;

    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 6;
    localparam int OP_W  = 3;

    typedef struct packed {
        logic [1:0]       kind;
        logic [TAG_W-1:0] tag;
        logic [OP_W-1:0]  op;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_clr = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [OP_W-1:0] in_op = '0;
    logic [1:0] in_dst = '0;
    logic [1:0] in_mode = '0;
    logic in_imm = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic slot_valid;
    logic slot_ready = 1'b1;
    logic [1:0] slot_kind;
    logic [OP_W-1:0] slot_op;
    logic [TAG_W-1:0] slot_tag;
    logic exe_load_v, exe_alu_v;
    logic [31:0] cnt_issued, cnt_executed;
    logic in_ready_n, slot_valid_n, el_n, ea_n;
    logic [1:0] kind_n;
    logic [OP_W-1:0] op_n;
    logic [TAG_W-1:0] tag_n;
    logic [2:0] iss_n, exe_n;

    int errors = 0;
    int checks = 0;
    item_t exp_q[$];
    string req_q[$];
    logic [31:0] m_iss = '0, m_exe = '0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic prev_stall = 1'b0;
    item_t prev_rec;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfuse_classifier #(.TAG_W(TAG_W), .OP_W(OP_W), .CNT_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr),
        .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_dst(in_dst),
        .in_mode(in_mode), .in_imm(in_imm), .in_tag(in_tag),
        .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_kind(slot_kind),
        .slot_op(slot_op), .slot_tag(slot_tag), .exe_load_v(exe_load_v),
        .exe_alu_v(exe_alu_v), .cnt_issued(cnt_issued), .cnt_executed(cnt_executed));

    // Narrow copy fed identically, used to observe counter wrap (R9).
    mfuse_classifier #(.TAG_W(TAG_W), .OP_W(OP_W), .CNT_W(3)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr),
        .in_valid(in_valid), .in_ready(in_ready_n), .in_op(in_op), .in_dst(in_dst),
        .in_mode(in_mode), .in_imm(in_imm), .in_tag(in_tag),
        .slot_valid(slot_valid_n), .slot_ready(slot_ready), .slot_kind(kind_n),
        .slot_op(op_n), .slot_tag(tag_n), .exe_load_v(el_n),
        .exe_alu_v(ea_n), .cnt_issued(iss_n), .cnt_executed(exe_n));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Expected slots, from R1..R5.
    task automatic send(input logic [1:0] mode, input logic [1:0] dst,
                        input logic imm, input logic [OP_W-1:0] op,
                        input logic [TAG_W-1:0] tag);
        item_t it;
        it.tag = tag;
        it.op  = op;
        if (mode == 2'd0) begin
            it.kind = 2'd0; exp_q.push_back(it); req_q.push_back("R1");
        end else if (mode == 2'd3 && imm) begin
            it.kind = 2'd2; exp_q.push_back(it); req_q.push_back("R3");
            it.kind = 2'd3; exp_q.push_back(it); req_q.push_back("R3");
        end else if (mode == 2'd2 && dst != 2'd2) begin
            it.kind = 2'd2; exp_q.push_back(it); req_q.push_back("R4");
            it.kind = 2'd3; exp_q.push_back(it); req_q.push_back("R4");
        end else begin
            it.kind = 2'd1; exp_q.push_back(it);
            req_q.push_back(mode == 2'd2 ? "R5" : "R2");
        end
        in_valid = 1'b1; in_mode = mode; in_dst = dst; in_imm = imm;
        in_op = op; in_tag = tag;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // Downstream readiness, changed just after each edge.
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            slot_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
        end
    end

    // Monitor: compares results against the scoreboard at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            item_t it;
            string rq;
            logic fire;
            check(cnt_issued == m_iss, "R8", "cnt_issued", cnt_issued, m_iss);
            check(cnt_executed == m_exe, "R8", "cnt_executed", cnt_executed, m_exe);
            check(iss_n == m_iss[2:0] && exe_n == m_exe[2:0], "R9", "narrow wrap",
                  {iss_n, exe_n}, {m_iss[2:0], m_exe[2:0]});
            if (prev_stall && slot_valid)
                check({slot_kind, slot_tag, slot_op} == prev_rec, "R7", "stalled record",
                      {slot_kind, slot_tag, slot_op}, prev_rec);
            if (slot_valid && slot_kind == 2'd2)
                check(!in_ready, "R6", "in_ready during load half", in_ready, 0);
            fire = slot_valid && slot_ready;
            if (fire) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected slot", slot_tag, 0);
                end else begin
                    it = exp_q.pop_front();
                    rq = req_q.pop_front();
                    check({slot_kind, slot_tag, slot_op} == it, rq, "slot record",
                          {slot_kind, slot_tag, slot_op}, it);
                    check(exe_load_v == (it.kind == 2'd1 || it.kind == 2'd2) &&
                          exe_alu_v == (it.kind != 2'd2), rq, "uop lanes",
                          {exe_load_v, exe_alu_v}, {it.kind == 2'd1 || it.kind == 2'd2,
                          it.kind != 2'd2});
                end
            end
            if (cnt_clr) begin
                m_iss = '0; m_exe = '0;
            end else if (fire) begin
                m_iss = m_iss + 1;
                m_exe = m_exe + ((slot_kind == 2'd1) ? 2 : 1);
            end
            prev_stall = slot_valid && !slot_ready;
            prev_rec = {slot_kind, slot_tag, slot_op};
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R10", "watchdog expired", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!slot_valid, "R10", "slot_valid after reset", slot_valid, 0);
        check(cnt_issued == 0 && cnt_executed == 0, "R10", "counters after reset",
              cnt_issued | cnt_executed, 0);
        @(posedge clk); #1;

        // Directed cases, full readiness.
        send(2'd0, 2'd0, 1'b0, 3'd1, 6'd1);  // R1 no memory
        send(2'd1, 2'd0, 1'b0, 3'd2, 6'd2);  // R2 base
        send(2'd1, 2'd0, 1'b1, 3'd3, 6'd3);  // R2 base with immediate
        send(2'd3, 2'd0, 1'b0, 3'd4, 6'd4);  // R2 IP-relative without immediate
        send(2'd3, 2'd0, 1'b1, 3'd5, 6'd5);  // R3 IP-relative with immediate
        send(2'd3, 2'd2, 1'b1, 3'd6, 6'd6);  // R3 even with read-written dest
        send(2'd2, 2'd0, 1'b0, 3'd7, 6'd7);  // R4 index, reg dest
        send(2'd2, 2'd1, 1'b0, 3'd0, 6'd8);  // R4 index, mem dest
        send(2'd2, 2'd2, 1'b0, 3'd1, 6'd9);  // R5 index, read-written dest
        repeat (4) @(posedge clk); #1;

        // Backpressure plus mid-stream counter clear (R7, R9).
        rdy_mode = 1;
        fork
            begin
                for (int i = 0; i < 400; i++) begin
                    logic [1:0] dst_sel;
                    dst_sel = lfsr[5:4] == 2'd3 ? 2'd2 : lfsr[5:4];
                    send(lfsr[3:2], dst_sel, lfsr[7], lfsr[10:8], 6'(i));
                end
            end
            begin
                repeat (150) @(posedge clk);
                #1 cnt_clr = 1'b1;
                @(posedge clk); #1 cnt_clr = 1'b0;
            end
        join
        rdy_mode = 0;
        repeat (10) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        report();
    end

endmodule